// File: doc/BRIEF.md
# Double-Buffered Compare Reload Controller

This block is one compare channel of a 16-bit timer. Software writes a new compare value into a buffer register. The timer matches against a separate active register. A mode bit decides when a buffered value reaches the active register. In batch mode (mode bit 0) a write is held back and copied at the next period wrap. In anytime mode (mode bit 1) a write takes effect on the next clock edge. The block also holds the up-counter, which runs from zero to a programmable period and then wraps. It drives a one-cycle match output when the running counter equals the active compare value.

Batch reload is gated by a two-state reload controller. In state `RL_IDLE` there is no copy pending. A compare write in batch mode takes the transition *arm* into `RL_PEND`. From `RL_PEND`, the transition *commit* returns to `RL_IDLE` at a wrap, and the active register is loaded from the buffer in that cycle. The transition *cancel* also returns to `RL_IDLE`, at once, when software sets the mode bit to 1. A batch write that arrives in the same cycle as a wrap keeps the controller in `RL_PEND` (*re-arm*). A cancelled request is dropped for good. Clearing the mode bit again does not bring it back.

Top module: `cmp_reload_top`

## Requirements
- R1: A synchronous reset sets the counter, the buffer, the active compare value and the reload state to zero and the mode bit to 0 (batch). After reset, a compare write does not reach the active value before a wrap.
- R2: While `run_en` is 1 the counter steps by one per clock from 0 to the period value and then returns to 0. While `run_en` is 0 it holds its value.
- R3: In batch mode, a compare write leaves the active value unchanged until the next wrap. The active value then takes the buffered value on the edge at which the counter returns to 0.
- R4: In anytime mode, a compare write appears as the active value on the next clock edge.
- R5: Writing 1 to the mode bit discards a pending batch reload. Later wraps do not change the active value, even after the mode bit has been written back to 0.
- R6: A batch compare write in the same cycle as a wrap copies the previous buffer value. The new value is copied at the following wrap.
- R7: A compare write in the same cycle as a mode write of 1 is stored in the buffer but is never transferred, even after the mode bit has returned to 0.
- R8: `match_o` is 1 exactly when `run_en` is 1 and the counter equals the active value. A value that is only buffered has no effect on it.
- R9: The mode bit may be changed while the counter runs, and the new mode applies to compare writes from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run_en | input | 1 | Counter run enable |
| per_wr | input | 1 | Period register write strobe |
| per_data | input | 16 | Period value (counter maximum) |
| cmp_wr | input | 1 | Compare buffer write strobe |
| cmp_data | input | 16 | Compare value to write |
| mode_wr | input | 1 | Mode bit write strobe |
| mode_data | input | 1 | Mode value: 0 batch, 1 anytime |
| cnt_o | output | 16 | Current counter value |
| act_cmp_o | output | 16 | Active compare value |
| match_o | output | 1 | Compare match pulse |

## Verification
The hardest case to reach is a pending reload that is cancelled and then tried again after the mode bit returns to 0, together with the related case of a write that lands exactly on a wrap. The stimulus follows the counter from the ports. It waits until `cnt_o` shows the value just before the wanted edge, then issues the write, the cancelling mode write, or the write that coincides with the wrap in that exact cycle. It then keeps the active value under watch across the next two wraps.

// File: rtl/cmp_reload_pkg.sv
package cmp_reload_pkg;

    // Reload controller states
    typedef enum logic [0:0] {
        RL_IDLE = 1'b0,
        RL_PEND = 1'b1
    } rl_state_e;

    // Mode bit encodings
    typedef enum logic {
        MODE_BATCH   = 1'b0,
        MODE_ANYTIME = 1'b1
    } rl_mode_e;

endpackage

// File: rtl/cmp_period_counter.sv
module cmp_period_counter #(
    parameter int          CNT_W      = 16,
    parameter logic [CNT_W-1:0] RST_PERIOD = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_en,
    input  logic             per_wr,
    input  logic [CNT_W-1:0] per_data,
    output logic [CNT_W-1:0] cnt_o,
    output logic             xfer_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] per_q;
    logic             at_top;

    assign at_top = (cnt_q == per_q);
    assign xfer_o = run_en && at_top;
    assign cnt_o  = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            per_q <= RST_PERIOD;
        end else if (per_wr) begin
            per_q <= per_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (run_en) begin
            if (at_top) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R2
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (run_en && cnt_q == per_q) |=> (cnt_q == '0));

    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> $stable(cnt_q));

endmodule

// File: rtl/cmp_reload_fsm.sv
module cmp_reload_fsm
    import cmp_reload_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cmp_wr,
    input  logic mode_wr,
    input  logic mode_data,
    input  logic xfer,
    output logic batch_load_o,
    output logic direct_load_o
);

    rl_state_e state_q;
    rl_state_e state_d;
    rl_mode_e  mode_q;
    logic      cancel;
    logic      arm;

    assign cancel = mode_wr && mode_data;
    assign arm    = cmp_wr && (mode_q == MODE_BATCH) && !cancel;

    // mode bit register
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_BATCH;
        end else if (mode_wr) begin
            mode_q <= rl_mode_e'(mode_data);
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RL_IDLE: begin
                if (arm) state_d = RL_PEND;          // arm
            end
            RL_PEND: begin
                if (cancel)            state_d = RL_IDLE;  // cancel
                else if (xfer && !arm) state_d = RL_IDLE;  // commit
                else                   state_d = RL_PEND;  // wait or re-arm
            end
            default: state_d = RL_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RL_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs
    always_comb begin
        batch_load_o  = 1'b0;
        direct_load_o = 1'b0;
        unique case (state_q)
            RL_IDLE: batch_load_o = 1'b0;
            RL_PEND: batch_load_o = xfer && !cancel;
            default: batch_load_o = 1'b0;
        endcase
        if (cmp_wr && mode_q == MODE_ANYTIME) begin
            direct_load_o = 1'b1;
        end
    end

    // R5
    cancel_drops_pending_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_wr && mode_data) |=> (state_q == RL_IDLE));

    // R3
    load_only_when_pending_chk: assert property (@(posedge clk) disable iff (rst)
        batch_load_o |-> (state_q == RL_PEND && mode_q == MODE_BATCH));

    // R9
    single_load_source_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({batch_load_o, direct_load_o}));

endmodule

// File: rtl/cmp_value_regs.sv
module cmp_value_regs #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_data,
    input  logic             batch_load,
    input  logic             direct_load,
    output logic [CNT_W-1:0] act_o
);

    logic [CNT_W-1:0] buf_q;
    logic [CNT_W-1:0] act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q <= '0;
        end else if (cmp_wr) begin
            buf_q <= cmp_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= '0;
        end else if (direct_load) begin
            act_q <= cmp_data;
        end else if (batch_load) begin
            act_q <= buf_q;
        end
    end

    assign act_o = act_q;

    // R3
    act_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!batch_load && !direct_load) |=> $stable(act_q));

    // R4
    direct_takes_data_chk: assert property (@(posedge clk) disable iff (rst)
        direct_load |=> (act_q == $past(cmp_data)));

endmodule

// File: rtl/cmp_reload_top.sv
module cmp_reload_top #(
    parameter int          CNT_W      = 16,
    parameter logic [CNT_W-1:0] RST_PERIOD = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_en,
    input  logic             per_wr,
    input  logic [CNT_W-1:0] per_data,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_data,
    input  logic             mode_wr,
    input  logic             mode_data,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] act_cmp_o,
    output logic             match_o
);

    logic xfer;
    logic batch_load;
    logic direct_load;

    cmp_period_counter #(
        .CNT_W      (CNT_W),
        .RST_PERIOD (RST_PERIOD)
    ) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .run_en   (run_en),
        .per_wr   (per_wr),
        .per_data (per_data),
        .cnt_o    (cnt_o),
        .xfer_o   (xfer)
    );

    cmp_reload_fsm u_fsm (
        .clk           (clk),
        .rst           (rst),
        .cmp_wr        (cmp_wr),
        .mode_wr       (mode_wr),
        .mode_data     (mode_data),
        .xfer          (xfer),
        .batch_load_o  (batch_load),
        .direct_load_o (direct_load)
    );

    cmp_value_regs #(
        .CNT_W (CNT_W)
    ) u_regs (
        .clk         (clk),
        .rst         (rst),
        .cmp_wr      (cmp_wr),
        .cmp_data    (cmp_data),
        .batch_load  (batch_load),
        .direct_load (direct_load),
        .act_o       (act_cmp_o)
    );

    assign match_o = run_en && (cnt_o == act_cmp_o);

    // R3
    batch_only_at_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        batch_load |-> xfer);

endmodule

// File: tb/cmp_reload_tb.sv
module cmp_reload_top_tb_top;

    typedef struct {
        int          due;
        bit          ck_c;
        logic [15:0] c;
        bit          ck_a;
        logic [15:0] a;
        bit          ck_m;
        logic        m;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run_en = 1'b0;
    logic        per_wr = 1'b0;
    logic [15:0] per_data = '0;
    logic        cmp_wr = 1'b0;
    logic [15:0] cmp_data = '0;
    logic        mode_wr = 1'b0;
    logic        mode_data = 1'b0;
    logic [15:0] cnt_o;
    logic [15:0] act_cmp_o;
    logic        match_o;

    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    item_t q[$];

    always #2.5 clk = ~clk;

    cmp_reload_top dut_i (
        .clk       (clk),
        .rst       (rst),
        .run_en    (run_en),
        .per_wr    (per_wr),
        .per_data  (per_data),
        .cmp_wr    (cmp_wr),
        .cmp_data  (cmp_data),
        .mode_wr   (mode_wr),
        .mode_data (mode_data),
        .cnt_o     (cnt_o),
        .act_cmp_o (act_cmp_o),
        .match_o   (match_o)
    );

    task automatic expect_at(input int off, input bit ck_c, input logic [15:0] c,
                             input bit ck_a, input logic [15:0] a,
                             input bit ck_m, input logic m, input string tag);
        item_t it;
        it.due = cyc + off; it.ck_c = ck_c; it.c = c; it.ck_a = ck_a; it.a = a;
        it.ck_m = ck_m; it.m = m; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic exp_act(input int off, input logic [15:0] a, input string tag);
        expect_at(off, 1'b0, '0, 1'b1, a, 1'b0, 1'b0, tag);
    endtask

    task automatic tick();
        @(negedge clk);
        cmp_wr  = 1'b0;
        mode_wr = 1'b0;
        per_wr  = 1'b0;
    endtask

    task automatic wait_cnt(input logic [15:0] v);
        tick();
        while (cnt_o !== v) tick();
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            #1;
            for (int i = q.size() - 1; i >= 0; i--) begin
                if (q[i].due == cyc) begin
                    if (q[i].ck_c) begin
                        checks++;
                        if (cnt_o !== q[i].c) begin
                            errors++;
                            $display("FAIL %s cnt actual %0d expected %0d", q[i].tag, cnt_o, q[i].c);
                        end
                    end
                    if (q[i].ck_a) begin
                        checks++;
                        if (act_cmp_o !== q[i].a) begin
                            errors++;
                            $display("FAIL %s act actual %0d expected %0d", q[i].tag, act_cmp_o, q[i].a);
                        end
                    end
                    if (q[i].ck_m) begin
                        checks++;
                        if (match_o !== q[i].m) begin
                            errors++;
                            $display("FAIL %s match actual %0b expected %0b", q[i].tag, match_o, q[i].m);
                        end
                    end
                    q.delete(i);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R2 watchdog actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // driver
    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        expect_at(1, 1'b1, 16'd0, 1'b1, 16'd0, 1'b1, 1'b0, "R1");
        tick();
        rst = 1'b0;
        per_wr = 1'b1; per_data = 16'd7;
        tick();

        // R2 counting and wrap, match at 0 since active is 0
        run_en = 1'b1;
        for (int i = 1; i <= 9; i++)
            expect_at(i, 1'b1, 16'(i % 8), 1'b1, 16'd0, 1'b1, (i % 8) == 0, "R2");
        repeat (9) tick();
        run_en = 1'b0;
        for (int i = 1; i <= 3; i++)
            expect_at(i, 1'b1, 16'd1, 1'b0, '0, 1'b1, 1'b0, "R2_hold");
        repeat (3) tick();
        run_en = 1'b1;

        // R3 batch write held until wrap
        wait_cnt(16'd2);
        cmp_wr = 1'b1; cmp_data = 16'd5;
        exp_act(1, 16'd0, "R3");
        wait_cnt(16'd7);
        expect_at(1, 1'b1, 16'd0, 1'b1, 16'd5, 1'b1, 1'b0, "R3");
        wait_cnt(16'd4);
        expect_at(1, 1'b1, 16'd5, 1'b1, 16'd5, 1'b1, 1'b1, "R8");
        expect_at(2, 1'b1, 16'd6, 1'b0, '0, 1'b1, 1'b0, "R8");
        // R8 buffered value does not match
        wait_cnt(16'd1);
        cmp_wr = 1'b1; cmp_data = 16'd3;
        wait_cnt(16'd2);
        expect_at(1, 1'b1, 16'd3, 1'b1, 16'd5, 1'b1, 1'b0, "R8");
        wait_cnt(16'd4);
        expect_at(1, 1'b1, 16'd5, 1'b0, '0, 1'b1, 1'b1, "R8");
        wait_cnt(16'd7);
        exp_act(1, 16'd3, "R3");

        // R4 and R9 anytime mode while running
        tick();
        mode_wr = 1'b1; mode_data = 1'b1;
        wait_cnt(16'd2);
        cmp_wr = 1'b1; cmp_data = 16'd6;
        exp_act(1, 16'd6, "R4");
        wait_cnt(16'd5);
        expect_at(1, 1'b1, 16'd6, 1'b0, '0, 1'b1, 1'b1, "R9");

        // R5 cancel then return to batch
        tick();
        mode_wr = 1'b1; mode_data = 1'b0;
        wait_cnt(16'd1);
        cmp_wr = 1'b1; cmp_data = 16'd2;
        exp_act(1, 16'd6, "R5");
        tick();
        mode_wr = 1'b1; mode_data = 1'b1;
        tick();
        mode_wr = 1'b1; mode_data = 1'b0;
        wait_cnt(16'd7);
        exp_act(1, 16'd6, "R5");
        wait_cnt(16'd7);
        exp_act(1, 16'd6, "R5");

        // R6 write coinciding with wrap
        wait_cnt(16'd1);
        cmp_wr = 1'b1; cmp_data = 16'd4;
        exp_act(1, 16'd6, "R6");
        wait_cnt(16'd7);
        cmp_wr = 1'b1; cmp_data = 16'd1;
        exp_act(1, 16'd4, "R6");
        wait_cnt(16'd7);
        exp_act(1, 16'd1, "R6");

        // R7 write together with cancelling mode write
        wait_cnt(16'd2);
        mode_wr = 1'b1; mode_data = 1'b1;
        cmp_wr = 1'b1; cmp_data = 16'd3;
        exp_act(1, 16'd1, "R7");
        wait_cnt(16'd7);
        exp_act(1, 16'd1, "R7");
        tick();
        mode_wr = 1'b1; mode_data = 1'b0;
        wait_cnt(16'd7);
        exp_act(1, 16'd1, "R7");

        // R8 match gated by run enable
        tick();
        mode_wr = 1'b1; mode_data = 1'b1;
        wait_cnt(16'd2);
        cmp_wr = 1'b1; cmp_data = 16'd3;
        exp_act(1, 16'd3, "R4");
        wait_cnt(16'd3);
        run_en = 1'b0;
        expect_at(1, 1'b1, 16'd3, 1'b0, '0, 1'b1, 1'b0, "R8");
        tick();
        tick();

        // R1 reset mid-run, mode back to batch
        run_en = 1'b1;
        tick();
        rst = 1'b1;
        expect_at(1, 1'b1, 16'd0, 1'b1, 16'd0, 1'b0, 1'b0, "R1");
        tick();
        rst = 1'b0;
        run_en = 1'b0;
        cmp_wr = 1'b1; cmp_data = 16'd7;
        exp_act(1, 16'd0, "R1");
        repeat (4) tick();

        if (q.size() != 0) begin
            errors++;
            $display("FAIL R2 pending items actual %0d expected 0", q.size());
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule